// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status-Holding Register

This block takes an asynchronous serial line and a one-cycle tick that fires sixteen times per bit period. A tick that finds the line low starts a frame. Each bit is decided from the majority of three samples taken around the middle of its sixteen ticks. The frame layout comes from a two-bit format select: eight data bits with one stop, eight data bits plus parity with one stop, eight data bits with two stops, or nine data bits with one stop. Data is sent least significant bit first.

When the last stop bit has been sampled, the block writes the word into a holding register in the system clock domain. The frame-error and noise flags for that word are written in the same step, and the full flag is set. The host takes the word and pulses a read strobe, which empties the register. A word that arrives while the register is still full raises an overrun flag. The block also raises a break flag when it sees a long run of zero bits. Each of the full, overrun and break flags drives its own interrupt request, gated by its own enable.

Top module: `serial_rx_hold`

## Requirements
- R1: While reset is high and after it is released, the data is 0, the full, overrun, break, frame-error and noise flags are 0 and all three interrupt requests are low.
- R2: A tick that finds the line low is index 0 of the start bit, and each bit spans 16 ticks. The bit value is the majority of the samples at indices 7, 8 and 9. The word is sent least significant bit first. When the last stop bit has been sampled, the word appears on `rx_data` and `rx_full` goes to 1. In eight-bit formats, bit 8 of `rx_data` is 0.
- R3: The `fmt` encoding is: 0 = 8 data bits and 1 stop; 1 = 8 data bits, a parity bit and 1 stop; 2 = 8 data bits and 2 stops; 3 = 9 data bits and 1 stop.
- R4: In format 1, `par_odd`=1 selects odd parity and `par_odd`=0 selects even parity, counted over the 8 data bits plus the parity bit. A parity mismatch sets the frame-error flag of the stored word.
- R5: A stop bit sampled as 0 sets the frame-error flag. In format 2 this applies to either stop bit. The word is still stored.
- R6: The noise flag of the stored word is 1 when, in any bit of its frame, the three mid-bit samples do not all agree.
- R7: If the start bit is decided as 1, the receiver returns to idle and stores nothing.
- R8: A read strobe clears the full, overrun and break flags, unless a word completes in the same cycle.
- R9: If a word completes while the register is full and no read strobe is present, the overrun flag is set and the stored word and its flags are kept.
- R10: Ten consecutive decided bits of 0 set the break flag. The run restarts on a decided 1 and whenever the receiver returns to idle.
- R11: `irq_full`, `irq_ovr` and `irq_brk` each equal their flag ANDed with the matching enable input.
- R12: Frames are received correctly when three idle ticks separate one frame's final stop bit from the next start bit.
- R13: The frame-error and noise flags change only when a word is loaded into the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input; idles high |
| os_tick | input | 1 | Oversample enable, 16 per bit |
| fmt | input | 2 | Frame format select (see R3) |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_stb | input | 1 | Host read strobe |
| ie_full | input | 1 | Enable for the full interrupt |
| ie_ovr | input | 1 | Enable for the overrun interrupt |
| ie_brk | input | 1 | Enable for the break interrupt |
| rx_data | output | 9 | Stored word |
| rx_full | output | 1 | Holding register full |
| ovr_err | output | 1 | Overrun flag |
| brk_err | output | 1 | Break flag |
| frm_err | output | 1 | Frame error of the stored word |
| nse_err | output | 1 | Noise flag of the stored word |
| irq_full | output | 1 | Full interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |
| irq_brk | output | 1 | Break interrupt request |

## Verification
The assertions check the holding register on every cycle:
- A completed word loads an empty register.
- A read strobe empties it.
- An overrun leaves the stored word untouched.
- The error flags move only on a load.
- A break hit sets the break flag.
- A start bit is taken only from a low line.

Other behaviour shows only in the bench scenarios, which compare every cycle against the bench's reference model. This covers the majority vote under an injected bad sample, parity polarity, a missing first or second stop bit, nine-bit words, false starts, the exact length of the zero run that triggers a break, and frames separated by the minimum three-tick gap.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int WORD_W = 9;

    typedef enum logic [1:0] {
        FMT_8N1 = 2'd0,
        FMT_8P1 = 2'd1,
        FMT_8N2 = 2'd2,
        FMT_9N1 = 2'd3
    } frame_fmt_e;

    typedef enum logic [2:0] {
        DF_START,
        DF_DATA,
        DF_PAR,
        DF_STOP1,
        DF_STOP2
    } df_state_e;

    typedef struct packed {
        logic val;
        logic noise;
    } bit_dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              frame_err;
        logic              noise_err;
    } rx_word_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return !((a == b) && (b == c));
    endfunction

    function automatic logic [3:0] last_data_idx(input frame_fmt_e f);
        return (f == FMT_9N1) ? 4'd8 : 4'd7;
    endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx,
    input  logic     tick,
    input  logic     halt,
    output logic     active,
    output logic     bit_stb,
    output bit_dec_t bit_dec
);
    localparam int CW  = $clog2(OS_RATE);
    localparam int MID = OS_RATE / 2;

    logic [CW-1:0] cnt;
    logic          s_early;
    logic          s_mid;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cnt     <= '0;
            s_early <= 1'b0;
            s_mid   <= 1'b0;
            bit_stb <= 1'b0;
            bit_dec <= '0;
        end else begin
            bit_stb <= 1'b0;
            if (halt) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (!active) begin
                if (tick && !rx) begin
                    active <= 1'b1;
                    cnt    <= CW'(1);
                end
            end else if (tick) begin
                cnt <= (cnt == CW'(OS_RATE - 1)) ? '0 : cnt + CW'(1);
                if (cnt == CW'(MID - 1)) s_early <= rx;
                if (cnt == CW'(MID))     s_mid   <= rx;
                if (cnt == CW'(MID + 1)) begin
                    bit_stb       <= 1'b1;
                    bit_dec.val   <= maj3(s_early, s_mid, rx);
                    bit_dec.noise <= split3(s_early, s_mid, rx);
                end
            end
        end
    end

    // R2: a frame starts only from a low line
    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> !$past(rx));

    // R2: decisions are only issued inside an active frame
    assert_stb_active_R2: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> active);

endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_fmt_e fmt,
    input  logic       par_odd,
    input  logic       bit_stb,
    input  bit_dec_t   bit_dec,
    output logic       halt,
    output logic       done,
    output rx_word_t   word
);
    df_state_e         st;
    logic [3:0]        idx;
    logic [WORD_W-1:0] shreg;
    logic              par_acc;
    logic              err_acc;
    logic              nse_acc;
    logic              last_data;

    always_comb begin
        last_data      = (idx == last_data_idx(fmt));
        halt           = 1'b0;
        done           = 1'b0;
        word.data      = shreg;
        word.frame_err = err_acc | !bit_dec.val;
        word.noise_err = nse_acc | bit_dec.noise;
        if (bit_stb) begin
            case (st)
                DF_START: halt = bit_dec.val;
                DF_STOP1: begin
                    if (fmt != FMT_8N2) begin
                        halt = 1'b1;
                        done = 1'b1;
                    end
                end
                DF_STOP2: begin
                    halt = 1'b1;
                    done = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= DF_START;
            idx     <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            err_acc <= 1'b0;
            nse_acc <= 1'b0;
        end else if (bit_stb) begin
            case (st)
                DF_START: begin
                    if (!bit_dec.val) begin
                        st      <= DF_DATA;
                        idx     <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        err_acc <= 1'b0;
                        nse_acc <= bit_dec.noise;
                    end
                end
                DF_DATA: begin
                    shreg   <= shreg | (WORD_W'(bit_dec.val) << idx);
                    par_acc <= par_acc ^ bit_dec.val;
                    nse_acc <= nse_acc | bit_dec.noise;
                    idx     <= idx + 4'd1;
                    if (last_data) st <= (fmt == FMT_8P1) ? DF_PAR : DF_STOP1;
                end
                DF_PAR: begin
                    err_acc <= err_acc | ((par_acc ^ bit_dec.val) != par_odd);
                    nse_acc <= nse_acc | bit_dec.noise;
                    st      <= DF_STOP1;
                end
                DF_STOP1: begin
                    nse_acc <= nse_acc | bit_dec.noise;
                    if (!bit_dec.val) err_acc <= 1'b1;
                    st <= (fmt == FMT_8N2) ? DF_STOP2 : DF_START;
                end
                default: st <= DF_START;
            endcase
        end
    end

endmodule

// File: rtl/srx_break_det.sv
module srx_break_det #(
    parameter int RUN_LEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic bit_stb,
    input  logic bit_val,
    output logic hit
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run;

    assign hit = bit_stb && !bit_val && (run == CW'(RUN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            run <= '0;
        end else if (bit_stb) begin
            if (bit_val)                    run <= '0;
            else if (run != CW'(RUN_LEN))   run <= run + CW'(1);
        end
    end

endmodule

// File: rtl/srx_holding.sv
module srx_holding
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_word_t          word,
    input  logic              brk_hit,
    input  logic              rd,
    output logic [WORD_W-1:0] data,
    output logic              full,
    output logic              ovr,
    output logic              brk,
    output logic              ferr,
    output logic              nerr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
            brk  <= 1'b0;
            ferr <= 1'b0;
            nerr <= 1'b0;
        end else begin
            if (done) begin
                if (full && !rd) begin
                    ovr <= 1'b1;
                end else begin
                    data <= word.data;
                    ferr <= word.frame_err;
                    nerr <= word.noise_err;
                    full <= 1'b1;
                    ovr  <= 1'b0;
                end
            end else if (rd) begin
                full <= 1'b0;
                ovr  <= 1'b0;
            end
            if (brk_hit)  brk <= 1'b1;
            else if (rd)  brk <= 1'b0;
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        done && !full |=> full && (data == $past(word.data)));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        rd && !done |=> !full && !ovr);

    assert_overrun_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        done && full && !rd |=> ovr && $stable(data));

    assert_flags_on_load_R13: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(ferr) && $stable(nerr));

    assert_break_sets_R10: assert property (@(posedge clk) disable iff (rst)
        brk_hit |=> brk);

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
    import srx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int BRK_RUN = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic [1:0]        fmt,
    input  logic              par_odd,
    input  logic              rd_stb,
    input  logic              ie_full,
    input  logic              ie_ovr,
    input  logic              ie_brk,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_full,
    output logic              ovr_err,
    output logic              brk_err,
    output logic              frm_err,
    output logic              nse_err,
    output logic              irq_full,
    output logic              irq_ovr,
    output logic              irq_brk
);
    logic     active;
    logic     bit_stb;
    bit_dec_t bit_dec;
    logic     halt;
    logic     done;
    rx_word_t word;
    logic     brk_hit;

    srx_sampler #(.OS_RATE(OS_RATE)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .rx      (rx_line),
        .tick    (os_tick),
        .halt    (halt),
        .active  (active),
        .bit_stb (bit_stb),
        .bit_dec (bit_dec)
    );

    srx_deframer u_deframer (
        .clk     (clk),
        .rst     (rst),
        .fmt     (frame_fmt_e'(fmt)),
        .par_odd (par_odd),
        .bit_stb (bit_stb),
        .bit_dec (bit_dec),
        .halt    (halt),
        .done    (done),
        .word    (word)
    );

    srx_break_det #(.RUN_LEN(BRK_RUN)) u_break (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .bit_stb (bit_stb),
        .bit_val (bit_dec.val),
        .hit     (brk_hit)
    );

    srx_holding u_hold (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .word    (word),
        .brk_hit (brk_hit),
        .rd      (rd_stb),
        .data    (rx_data),
        .full    (rx_full),
        .ovr     (ovr_err),
        .brk     (brk_err),
        .ferr    (frm_err),
        .nerr    (nse_err)
    );

    assign irq_full = rx_full & ie_full;
    assign irq_ovr  = ovr_err & ie_ovr;
    assign irq_brk  = brk_err & ie_brk;

endmodule

// File: tb/serial_rx_hold_tb.sv
module serial_rx_hold_tb;
    localparam int TDIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic [1:0] fmt = 2'd0;
    logic       par_odd = 1'b0;
    logic       rd_stb = 1'b0;
    logic       ie_full = 1'b1, ie_ovr = 1'b1, ie_brk = 1'b1;
    logic [8:0] rx_data;
    logic       rx_full, ovr_err, brk_err, frm_err, nse_err;
    logic       irq_full, irq_ovr, irq_brk;

    always #2 clk = ~clk;

    serial_rx_hold u_dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick), .fmt(fmt),
        .par_odd(par_odd), .rd_stb(rd_stb), .ie_full(ie_full), .ie_ovr(ie_ovr),
        .ie_brk(ie_brk), .rx_data(rx_data), .rx_full(rx_full), .ovr_err(ovr_err),
        .brk_err(brk_err), .frm_err(frm_err), .nse_err(nse_err),
        .irq_full(irq_full), .irq_ovr(irq_ovr), .irq_brk(irq_brk)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // reference model state
    int         q_due[$];
    logic [11:0] q_pay[$];
    logic [8:0] m_data = '0;
    logic       m_full = 0, m_ovr = 0, m_brk = 0, m_ferr = 0, m_nerr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        logic        ev;
        logic [11:0] p;
        cyc = cyc + 1;
        ev = 0;
        p  = '0;
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            ev = 1;
            void'(q_due.pop_front());
            p = q_pay.pop_front();
        end
        if (rst) begin
            m_data = '0; m_full = 0; m_ovr = 0; m_brk = 0; m_ferr = 0; m_nerr = 0;
        end else begin
            if (ev) begin
                if (m_full && !rd_stb) m_ovr = 1;
                else begin
                    m_data = p[8:0]; m_ferr = p[9]; m_nerr = p[10];
                    m_full = 1; m_ovr = 0;
                end
            end else if (rd_stb) begin
                m_full = 0; m_ovr = 0;
            end
            if (ev && p[11]) m_brk = 1;
            else if (rd_stb) m_brk = 0;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cyc > 0 && !finished) begin
            chk(rx_data == m_data, "R2 data", rx_data, m_data);
            chk(rx_full == m_full, "R8 full", rx_full, m_full);
            chk(ovr_err == m_ovr,  "R9 overrun", ovr_err, m_ovr);
            chk(brk_err == m_brk,  "R10 break", brk_err, m_brk);
            chk(frm_err == m_ferr, "R5 frame_err", frm_err, m_ferr);
            chk(nse_err == m_nerr, "R6 noise", nse_err, m_nerr);
            chk(irq_full == (m_full & ie_full), "R11 irq_full", irq_full, m_full & ie_full);
            chk(irq_ovr  == (m_ovr & ie_ovr),   "R11 irq_ovr",  irq_ovr,  m_ovr & ie_ovr);
            chk(irq_brk  == (m_brk & ie_brk),   "R11 irq_brk",  irq_brk,  m_brk & ie_brk);
        end
    end

    task automatic one_tick(input logic lvl, input bit push, input logic [11:0] pay);
        repeat (TDIV - 1) begin
            @(negedge clk);
            os_tick = 1'b0;
        end
        @(negedge clk);
        os_tick = 1'b1;
        rx_line = lvl;
        if (push) begin
            q_due.push_back(cyc + 2);
            q_pay.push_back(pay);
        end
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) one_tick(1'b1, 0, '0);
    endtask

    task automatic do_read();
        @(negedge clk);
        os_tick = 1'b0;
        rd_stb  = 1'b1;
        @(negedge clk);
        rd_stb  = 1'b0;
    endtask

    // noisy_bit: frame bit index whose sample 8 is inverted, -1 for none
    task automatic send_frame(input logic [8:0] d, input logic [1:0] f, input logic podd,
                              input bit pflip, input logic st1, input logic st2,
                              input int noisy_bit);
        logic bits[$];
        int   nb;
        int   run;
        logic brk;
        logic ferr;
        logic [8:0] dexp;
        logic [11:0] pay;
        fmt     = f;
        par_odd = podd;
        nb = (f == 2'd3) ? 9 : 8;
        bits.push_back(1'b0);
        for (int i = 0; i < nb; i++) bits.push_back(d[i]);
        if (f == 2'd1) bits.push_back((^d[7:0]) ^ podd ^ pflip);
        bits.push_back(st1);
        if (f == 2'd2) bits.push_back(st2);
        run = 0;
        brk = 0;
        foreach (bits[k]) begin
            run = bits[k] ? 0 : run + 1;
            if (run == 10) brk = 1;
        end
        ferr = ((f == 2'd1) && pflip) || !st1 || ((f == 2'd2) && !st2);
        dexp = (nb == 9) ? d : {1'b0, d[7:0]};
        pay  = {brk, (noisy_bit >= 0), ferr, dexp};
        foreach (bits[k]) begin
            for (int t = 0; t < 16; t++) begin
                logic lv;
                lv = bits[k];
                if (k == noisy_bit && t == 8) lv = ~lv;
                one_tick(lv, (k == bits.size() - 1) && (t == 9), pay);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rx_data == 0 && !rx_full && !ovr_err && !brk_err && !frm_err && !nse_err,
            "R1 reset flags", {rx_full, ovr_err, brk_err, frm_err, nse_err}, 0);
        chk(!irq_full && !irq_ovr && !irq_brk, "R1 reset irqs", {irq_full, irq_ovr, irq_brk}, 0);
        rst = 1'b0;
        idle_ticks(5);

        // R2 R3: format 0, LSB first
        send_frame(9'h0A5, 2'd0, 0, 0, 1, 1, -1);
        idle_ticks(3);
        chk(rx_full && rx_data == 9'h0A5 && !frm_err, "R2 8N1 word", rx_data, 9'h0A5);
        do_read();
        chk(!rx_full, "R8 read empties", rx_full, 0);

        // R4: even parity, good
        send_frame(9'h03C, 2'd1, 0, 0, 1, 1, -1);
        idle_ticks(3);
        chk(!frm_err && rx_data == 9'h03C, "R4 even parity ok", frm_err, 0);
        do_read();
        // R4: odd parity, wrong parity bit
        send_frame(9'h0C3, 2'd1, 1, 1, 1, 1, -1);
        idle_ticks(3);
        chk(frm_err, "R4 odd parity fail", frm_err, 1);
        do_read();
        // R4: odd parity, good
        send_frame(9'h017, 2'd1, 1, 0, 1, 1, -1);
        idle_ticks(3);
        chk(!frm_err, "R4 odd parity ok", frm_err, 0);
        do_read();

        // R5: second stop low in format 2
        send_frame(9'h081, 2'd2, 0, 0, 1, 0, -1);
        idle_ticks(6);
        chk(frm_err && rx_data == 9'h081, "R5 second stop", frm_err, 1);
        do_read();
        // R5: first stop low in format 0
        send_frame(9'h066, 2'd0, 0, 0, 0, 1, -1);
        idle_ticks(6);
        chk(frm_err && rx_full, "R5 missing stop", frm_err, 1);
        do_read();

        // R3: nine-bit word
        send_frame(9'h12B, 2'd3, 0, 0, 1, 1, -1);
        idle_ticks(3);
        chk(rx_data == 9'h12B, "R3 nine-bit", rx_data, 9'h12B);
        do_read();

        // R6: bad mid sample on data bit 3, majority still correct
        send_frame(9'h05A, 2'd0, 0, 0, 1, 1, 4);
        idle_ticks(3);
        chk(nse_err && rx_data == 9'h05A, "R6 noise flag", nse_err, 1);
        do_read();

        // R7: false start
        for (int i = 0; i < 4; i++) one_tick(1'b0, 0, '0);
        idle_ticks(30);
        chk(!rx_full, "R7 false start stored nothing", rx_full, 0);

        // R9 R13 R11: overrun, second word noisy and dropped
        send_frame(9'h011, 2'd0, 0, 0, 1, 1, -1);
        idle_ticks(3);
        send_frame(9'h022, 2'd0, 0, 0, 1, 1, 2);
        idle_ticks(3);
        chk(ovr_err && rx_data == 9'h011, "R9 overrun keeps word", rx_data, 9'h011);
        chk(!nse_err, "R13 flags kept on overrun", nse_err, 0);
        chk(irq_ovr, "R11 irq_ovr", irq_ovr, 1);
        @(negedge clk);
        ie_ovr = 1'b0;
        @(negedge clk);
        chk(!irq_ovr, "R11 irq_ovr gated", irq_ovr, 0);
        ie_ovr = 1'b1;
        do_read();
        chk(!ovr_err && !rx_full, "R8 read clears overrun", ovr_err, 0);

        // R10: nine zeros then a good stop -> no break
        send_frame(9'h000, 2'd0, 0, 0, 1, 1, -1);
        idle_ticks(3);
        chk(!brk_err, "R10 nine zeros no break", brk_err, 1'b0);
        do_read();
        // R10: ten zeros -> break
        send_frame(9'h000, 2'd0, 0, 0, 0, 1, -1);
        idle_ticks(6);
        chk(brk_err && irq_brk && frm_err, "R10 break", brk_err, 1);
        do_read();
        chk(!brk_err, "R8 read clears break", brk_err, 0);

        // R12: back-to-back with a three-tick gap
        send_frame(9'h0F0, 2'd0, 0, 0, 1, 1, -1);
        idle_ticks(3);
        chk(rx_data == 9'h0F0, "R12 first word", rx_data, 9'h0F0);
        do_read();
        send_frame(9'h00F, 2'd0, 0, 0, 1, 1, -1);
        idle_ticks(3);
        chk(rx_data == 9'h00F && !ovr_err, "R12 second word", rx_data, 9'h00F);
        do_read();
        send_frame(9'h1C3, 2'd3, 0, 0, 1, 1, -1);
        idle_ticks(3);
        chk(rx_data == 9'h1C3, "R12 third word", rx_data, 9'h1C3);
        @(negedge clk);
        ie_full = 1'b0;
        @(negedge clk);
        chk(!irq_full && rx_full, "R11 irq_full gated", irq_full, 0);
        do_read();
        idle_ticks(4);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule